// File: doc/BRIEF.md
# Embedded-Clock DC-Balanced Frame Serializer

This block turns a stream of 24-bit parallel words into a single serial bit stream with the clock embedded in it. Each word becomes a 28-bit frame. The frame holds the 24 payload bits and four overhead bits. Two of the overhead bits are fixed at 1 and 0, so every frame has a guaranteed rising edge that a receiver can lock onto. The other two are a balance flag and a parity bit.

A balance stage keeps a signed running count of ones minus zeros over the payload bits already sent. When the next payload would push that count further in the direction it already leans, the stage inverts the payload and sets the flag. Frame timing is derived from one bit clock. A frame counter marks the cycle in which the parallel word is sampled, which happens once every 28 bit-clock cycles. A word sampled at one frame boundary is sent in the frame that starts at the next boundary.

The serial output is live only while the enable input is high and the active-low power-down input is high. Power-down also returns the framer to its reset state.

Top module: `ser_frame_tx`

## Requirements
- R1: Immediately after reset, `word_take` is 1, and the first frame sent carries an all-zero payload with the balance flag and the parity bit both 0.
- R2: `word_take` is high for exactly one bit-clock cycle in every 28. `par_data` is sampled on the rising clock edge that ends that cycle.
- R3: Frame position 0 is always 1 and frame position 27 is always 0. Positions are counted in transmit order, starting with the first cycle after the load edge.
- R4: Frame positions 1 to 24 carry the payload, least significant bit first. A word sampled at frame boundary k is transmitted in the frame that starts at boundary k+1.
- R5: The payload disparity is (2 × number of ones − 24), and the running disparity starts at 0. The payload is inverted only when its disparity is nonzero, the running disparity is nonzero, and both have the same sign. The running disparity then adds the disparity of the payload as actually sent.
- R6: Frame position 25 is 1 when the payload in that frame is inverted, and 0 otherwise.
- R7: Frame position 26 makes the number of ones in positions 1 to 26 even.
- R8: `ser_active` equals `tx_en` AND `pd_n`. While `ser_active` is 0, `ser_bit` is 0.
- R9: A clock edge with `pd_n` low clears the framer to its reset state: the held word is zero, the running disparity is zero, and the next cycle is a word-take cycle. `word_take` is 0 while `pd_n` is low.
- R10: `tx_en` low hides the output but has no effect on framing, word capture or the running disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 28 times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_data | input | 24 | Parallel payload word, sampled when `word_take` is high |
| tx_en | input | 1 | Output enable |
| pd_n | input | 1 | Active-low power-down; low clears the framer |
| ser_bit | output | 1 | Serial frame bit |
| ser_active | output | 1 | 1 = output driven, 0 = output reported high-impedance |
| word_take | output | 1 | High in the cycle whose closing edge samples `par_data` |

## Verification
The balance state is visible only through the payload polarity and the flag bit, one frame after the word that caused it. A wrong running disparity therefore shows up as a flipped payload and flag in the next frame, and the parity bit is wrong in that same frame. A slipped frame counter moves the fixed 1 and 0 bits away from positions 0 and 27 within one frame, and it shifts the `word_take` pulse. A power-down that fails to clear the state shows up in the first frame after power-up, either as a non-zero payload or as an unexpected inversion.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  localparam int unsigned PAY_W    = 24;
  localparam int unsigned OVH_W    = 4;
  localparam int unsigned FRAME_W  = PAY_W + OVH_W;
  localparam int unsigned IDX_W    = $clog2(FRAME_W);
  localparam int unsigned DISP_W   = $clog2(PAY_W + 1) + 2;
  localparam int unsigned POS_CLK1 = 0;
  localparam int unsigned POS_PAY  = 1;
  localparam int unsigned POS_DCB  = PAY_W + 1;
  localparam int unsigned POS_DCA  = PAY_W + 2;
  localparam int unsigned POS_CLK0 = PAY_W + 3;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  typedef logic [PAY_W-1:0]          pay_t;
  typedef logic [FRAME_W-1:0]        frame_t;
  typedef logic signed [DISP_W-1:0]  disp_t;

  // ones minus zeros of a payload word
  function automatic disp_t word_disp(input pay_t w);
    int ones;
    ones = 0;
    for (int i = 0; i < int'(PAY_W); i++) ones += int'(w[i]);
    return disp_t'(2 * ones - int'(PAY_W));
  endfunction

  // invert when the word would push the running total further the same way
  function automatic logic want_invert(input disp_t d, input disp_t run);
    return (d != '0) && (run != '0) && (d[DISP_W-1] == run[DISP_W-1]);
  endfunction

  function automatic frame_t pack_frame(input pay_t sent, input logic dcb);
    frame_t f;
    f                    = '0;
    f[POS_CLK1]          = 1'b1;
    f[POS_PAY +: PAY_W]  = sent;
    f[POS_DCB]           = dcb;
    f[POS_DCA]           = ^{sent, dcb};
    f[POS_CLK0]          = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/ser_frame_ctr.sv
module ser_frame_ctr
  import ser_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  output logic [IDX_W-1:0] idx,
  output logic             wrap
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= IDX_LAST;
    else if (!pd_n)            idx_q <= IDX_LAST;
    else if (idx_q == IDX_LAST) idx_q <= '0;
    else                       idx_q <= idx_q + 1'b1;
  end

  assign idx  = idx_q;
  assign wrap = pd_n && (idx_q == IDX_LAST);
endmodule

// File: rtl/ser_dc_balance.sv
module ser_dc_balance
  import ser_frame_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pd_n,
  input  logic  load,
  input  pay_t  pay_in,
  output pay_t  pay_sent,
  output logic  inv,
  output disp_t run
);
  disp_t run_q;
  disp_t d_raw;
  disp_t d_sent;

  always_comb begin
    d_raw    = word_disp(pay_in);
    inv      = want_invert(d_raw, run_q);
    pay_sent = inv ? ~pay_in : pay_in;
    d_sent   = inv ? -d_raw : d_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (!pd_n) run_q <= '0;
    else if (load)  run_q <= run_q + d_sent;
  end

  assign run = run_q;
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift
  import ser_frame_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic load,
  input  pay_t par_in,
  input  pay_t pay_sent,
  input  logic inv,
  output pay_t hold,
  output logic bit_out
);
  pay_t   hold_q;
  frame_t shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shreg_q <= '0;
    end else if (!pd_n) begin
      hold_q  <= '0;
      shreg_q <= '0;
    end else if (load) begin
      hold_q  <= par_in;
      shreg_q <= pack_frame(pay_sent, inv);
    end else begin
      shreg_q <= {1'b0, shreg_q[FRAME_W-1:1]};
    end
  end

  assign hold    = hold_q;
  assign bit_out = shreg_q[0];
endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W-1:0] par_data,
  input  logic             tx_en,
  input  logic             pd_n,
  output logic             ser_bit,
  output logic             ser_active,
  output logic             word_take
);
  logic [IDX_W-1:0] bit_idx;
  logic             load_evt;
  pay_t             hold_word;
  pay_t             pay_sent;
  logic             inv_flag;
  disp_t            run_disp;
  logic             raw_bit;

  ser_frame_ctr u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .pd_n (pd_n),
    .idx  (bit_idx),
    .wrap (load_evt)
  );

  ser_dc_balance u_bal (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_n    (pd_n),
    .load    (load_evt),
    .pay_in  (hold_word),
    .pay_sent(pay_sent),
    .inv     (inv_flag),
    .run     (run_disp)
  );

  ser_frame_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_n    (pd_n),
    .load    (load_evt),
    .par_in  (par_data),
    .pay_sent(pay_sent),
    .inv     (inv_flag),
    .hold    (hold_word),
    .bit_out (raw_bit)
  );

  assign ser_active = tx_en & pd_n;
  assign ser_bit    = ser_active & raw_bit;
  assign word_take  = load_evt;
endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk
  import ser_frame_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pd_n,
  input logic             ser_bit,
  input logic             ser_active,
  input logic             word_take,
  input logic [IDX_W-1:0] bit_idx,
  input logic             load_evt,
  input logic             inv_flag,
  input disp_t            run_disp
);
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && bit_idx != IDX_LAST) |=> (int'(bit_idx) == int'($past(bit_idx)) + 1)); // R2
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> !word_take); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (bit_idx == '0)); // R2
  AST_CLK1_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_active && bit_idx == '0) |-> ser_bit); // R3
  AST_CLK0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == IDX_LAST) |-> !ser_bit); // R3
  AST_DISP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_disp) <= int'(PAY_W)) && (int'(run_disp) >= -int'(PAY_W))); // R5
  AST_INV_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && inv_flag) |-> (run_disp != '0)); // R5
  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_active |-> !ser_bit); // R8
  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (bit_idx == IDX_LAST) && (run_disp == '0)); // R9
endmodule

bind ser_frame_tx ser_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pd_n      (pd_n),
  .ser_bit   (ser_bit),
  .ser_active(ser_active),
  .word_take (word_take),
  .bit_idx   (bit_idx),
  .load_evt  (load_evt),
  .inv_flag  (inv_flag),
  .run_disp  (run_disp)
);

// File: tb/ser_frame_tx_tb.sv
`timescale 1ns/1ps
module ser_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] par_data = '0;
  logic        tx_en = 1'b1;
  logic        pd_n = 1'b1;
  logic        ser_bit, ser_active, word_take;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [23:0] hold_m = '0;
  int          run_m = 0;
  logic [27:0] obs;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ser_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .par_data(par_data), .tx_en(tx_en),
    .pd_n(pd_n), .ser_bit(ser_bit), .ser_active(ser_active), .word_take(word_take)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // frame expected for a held word, restated bit by bit
  function automatic logic [27:0] model_frame(input logic [23:0] w, input int run, output int nrun);
    int ones, d, sones;
    bit inv;
    logic [23:0] s;
    logic [27:0] f;
    ones = 0;
    foreach (w[i]) if (w[i]) ones++;
    d = ones * 2 - 24;
    inv = (d != 0) && (run != 0) && ((d > 0) == (run > 0));
    s = inv ? ~w : w;
    nrun = run + (inv ? -d : d);
    sones = inv ? 24 - ones : ones;
    for (int j = 0; j < 28; j++) begin
      if (j == 0)       f[j] = 1'b1;
      else if (j <= 24) f[j] = s[j-1];
      else if (j == 25) f[j] = inv;
      else if (j == 26) f[j] = ((sones + int'(inv)) % 2) == 1;
      else              f[j] = 1'b0;
    end
    return f;
  endfunction

  function automatic string pos_req(input int j);
    if (j == 0 || j == 27) return "R3";
    if (j <= 24)           return "R4";
    if (j == 25)           return "R6";
    return "R7";
  endfunction

  // entered at a negedge inside a word-take cycle; leaves at the next one
  task automatic do_frame(input logic [23:0] w, input bit en, input string tag);
    logic [27:0] f;
    int nr;
    chk(word_take == 1'b1, {"R2 take ", tag}, word_take, 1);
    par_data = w;
    tx_en    = en;
    @(posedge clk);
    f = model_frame(hold_m, run_m, nr);
    run_m  = nr;
    hold_m = w;
    for (int j = 0; j < 28; j++) begin
      @(negedge clk);
      obs[j] = ser_bit;
      if (j < 27) chk(word_take == 1'b0, "R2 idle", word_take, 0);
      chk(ser_active == en, "R8 active", ser_active, en);
      chk(ser_bit == (en ? f[j] : 1'b0), {(en ? pos_req(j) : "R8"), " ", tag}, ser_bit, en ? f[j] : 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(word_take == 1'b1, "R1 take after reset", word_take, 1);
    chk(ser_active == 1'b1, "R8 active in reset", ser_active, 1);
    chk(ser_bit == 1'b0, "R1 idle bit", ser_bit, 0);
    rst_n = 1'b1;

    // R1: first frame is the cleared held word
    do_frame(24'h000000, 1'b1, "R1 first");
    chk(obs[24:1] == 24'h0 && obs[26:25] == 2'b00, "R1 zero frame", {8'h0, obs[24:1]}, 0);
    // R5: zeros again after a negative total must invert
    do_frame(24'hABCDEF, 1'b1, "R5 zero rerun");
    chk(obs[25] == 1'b1, "R5 invert", obs[25], 1);
    chk(obs[24:1] == 24'hFFFFFF, "R5 payload", {8'h0, obs[24:1]}, 24'hFFFFFF);
    do_frame(24'hFFFFFF, 1'b1, "R4 ordering");
    chk(obs[24:1] == 24'hABCDEF, "R4 lsb first", {8'h0, obs[24:1]}, 24'hABCDEF);
    do_frame(24'hFFFFFF, 1'b1, "R5 ones");
    do_frame(24'h000FFF, 1'b1, "R5 balanced");
    do_frame(24'h800001, 1'b1, "R7 parity");
    do_frame(24'h7FFFFE, 1'b1, "R6 flag");

    // R10: disabled frames still advance the model
    for (int k = 0; k < 6; k++) do_frame(24'($urandom), 1'b0, "R10 hidden");
    for (int k = 0; k < 4; k++) do_frame(24'($urandom), 1'b1, "R10 resumed");

    // R9: power-down at a boundary
    pd_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(word_take == 1'b0, "R9 take low", word_take, 0);
      chk(ser_active == 1'b0 && ser_bit == 1'b0, "R8 quiet", {ser_active, ser_bit}, 0);
    end
    pd_n = 1'b1; hold_m = '0; run_m = 0;
    #0;
    chk(word_take == 1'b1, "R9 take after wake", word_take, 1);
    do_frame(24'h00000F, 1'b1, "R9 after wake");
    chk(obs[24:1] == 24'h0, "R9 cleared hold", {8'h0, obs[24:1]}, 0);

    // R9: power-down in mid-frame
    par_data = 24'h123456;
    @(posedge clk);
    repeat (10) @(negedge clk);
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_bit == 1'b0 && word_take == 1'b0, "R9 mid quiet", {ser_bit, word_take}, 0);
    pd_n = 1'b1; hold_m = '0; run_m = 0;
    #0;
    do_frame(24'hFEDCBA, 1'b1, "R9 mid wake");

    for (int k = 0; k < 40; k++) do_frame(24'($urandom), ($urandom % 5) != 0, "R5 random");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule